// File: doc/BRIEF.md
# Guarded Thruster Valve Controller

This block drives a bank of thruster valve outputs and a pair of isolation valve outputs from a small synchronous register port. A thruster valve opens only while two independent bits agree: its arm bit and its fire bit. Arming is one register and firing is another, so a single corrupted write cannot open a valve by itself. Each thruster also has its own duration register, written ahead of time in clock ticks. When software sets a fire bit, the controller loads that duration into a per-thruster timer. The hardware then closes the valve when the time runs out, and software never has to clear it.

Each thruster also has its own watchdog. It counts how many consecutive cycles the valve has been open. If that count reaches a fixed limit, the watchdog forces the valve shut, drops both arm and fire, and latches a sticky trip flag. A dedicated cutoff input acts as a master isolation shutdown. While it is high, every thruster valve and both isolation valves are held closed and all pending firings are cancelled.

Software writes the duration registers, the arm mask, the isolation enables and the fire mask, in that order. It then polls the fire mask, the live valve status and the trip flags through the read port.

Top module: `thr_guard_ctrl`

## Requirements
- R1: After synchronous reset, every thruster and isolation valve output is low, and the arm (0x00), fire (0x01), isolation enable (0x02) and trip (0x03) registers all read zero.
- R2: Thruster valve i is open only while arm bit i (register 0x00) and fire bit i (register 0x01) are both set. A fire bit set on an unarmed thruster leaves its valve closed.
- R3: Register 0x10+i holds thruster i's duration as a 16-bit tick count and reads back as written. Writing fire bit i = 1 with a nonzero duration D opens an armed valve at that write's clock edge. The valve stays open for exactly D cycles, after which fire bit i clears by itself and arm bit i is kept.
- R4: A fire write of 1 to a thruster whose duration register is zero is ignored: its fire bit stays 0 and its valve stays closed.
- R5: Clearing arm bit i during a firing closes the valve on the next edge, keeps fire bit i set and freezes the remaining time. Re-arming opens the valve again for exactly the remaining cycles.
- R6: If valve i stays open for WD_LIMIT consecutive cycles, the watchdog closes it. It clears arm bit i and fire bit i, and sets trip bit i in register 0x03.
- R7: Trip bits are sticky. Writing 1 to bit i of register 0x03 clears trip bit i, and writing 0 leaves it unchanged.
- R8: While iso_cutoff is high, all thruster and isolation valve outputs are low from the next edge on, and every fire bit is cleared. Arm bits and isolation enables keep their values.
- R9: Isolation valve j follows bit j of register 0x02 one edge after the write, unless cutoff is active.
- R10: A read returns data on reg_rdata with reg_rvalid high one cycle after reg_rd. Address 0x04 returns the live thruster valve state, and unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| iso_cutoff | input | 1 | Master isolation shutdown |
| thr_valve | output | NUM_THR | Thruster valve drive, registered |
| iso_valve | output | NUM_ISO | Isolation valve drive, registered |

## Verification
The hardest situation to reach is a watchdog trip. A trip needs a valve held open continuously for the full limit, but normal firings are always shorter because the duration timer closes the valve first. The bench builds the block with a small limit. It loads one thruster with a duration well above that limit and counts the open cycles until the forced close, then reads back the trip, arm and fire registers. The arm-pause case is also hard to set up, because the arm write has to land in the middle of a running firing. The bench places that write a known number of edges after the fire write and then counts the remaining open cycles after re-arming.

// File: rtl/thr_guard_pkg.sv
package thr_guard_pkg;
  // register addresses
  localparam int A_ARM   = 0;
  localparam int A_FIRE  = 1;
  localparam int A_ISO   = 2;
  localparam int A_TRIP  = 3;
  localparam int A_VALVE = 4;
  localparam int A_DUR   = 16;

  // per-thruster write command decoded from the register port
  typedef struct packed {
    logic arm_wr;
    logic arm_val;
    logic fire_wr;
    logic fire_val;
    logic trip_clr;
    logic dur_wr;
  } chan_cmd_t;
endpackage

// File: rtl/thr_regif.sv
module thr_regif
  import thr_guard_pkg::*;
#(
  parameter int NUM_THR = 12,
  parameter int NUM_ISO = 2,
  parameter int DUR_W   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_THR-1:0]         arm_v,
  input  logic [NUM_THR-1:0]         fire_v,
  input  logic [NUM_THR-1:0]         trip_v,
  input  logic [NUM_THR-1:0]         valve_v,
  input  logic [NUM_ISO-1:0]         iso_v,
  input  logic [NUM_THR*DUR_W-1:0]   dur_flat,
  output chan_cmd_t [NUM_THR-1:0]    cmd,
  output logic                       iso_wr,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  logic [DATA_W-1:0] rdata_n;

  assign iso_wr = wr && (addr == ADDR_W'(A_ISO));

  for (genvar i = 0; i < NUM_THR; i++) begin : g_cmd
    assign cmd[i].arm_wr   = wr && (addr == ADDR_W'(A_ARM));
    assign cmd[i].arm_val  = wdata[i];
    assign cmd[i].fire_wr  = wr && (addr == ADDR_W'(A_FIRE));
    assign cmd[i].fire_val = wdata[i];
    assign cmd[i].trip_clr = wr && (addr == ADDR_W'(A_TRIP)) && wdata[i];
    assign cmd[i].dur_wr   = wr && (addr == ADDR_W'(A_DUR + i));
  end

  always_comb begin
    rdata_n = '0;
    if (addr == ADDR_W'(A_ARM))        rdata_n = DATA_W'(arm_v);
    else if (addr == ADDR_W'(A_FIRE))  rdata_n = DATA_W'(fire_v);
    else if (addr == ADDR_W'(A_ISO))   rdata_n = DATA_W'(iso_v);
    else if (addr == ADDR_W'(A_TRIP))  rdata_n = DATA_W'(trip_v);
    else if (addr == ADDR_W'(A_VALVE)) rdata_n = DATA_W'(valve_v);
    else begin
      for (int i = 0; i < NUM_THR; i++)
        if (addr == ADDR_W'(A_DUR + i))
          rdata_n = DATA_W'(dur_flat[i*DUR_W +: DUR_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rdata_n;
    end
  end

  // R10
  rvalid_chk: assert property (@(posedge clk) disable iff (rst) rd |=> rvalid);
  // R10
  no_spur_rvalid_chk: assert property (@(posedge clk) disable iff (rst) !rd |=> !rvalid);
endmodule

// File: rtl/thr_channel.sv
module thr_channel
  import thr_guard_pkg::*;
#(
  parameter int DUR_W    = 16,
  parameter int WD_LIMIT = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_cmd_t        cmd,
  input  logic [DUR_W-1:0] wdur,
  input  logic             cutoff,
  output logic             arm_o,
  output logic             fire_o,
  output logic             trip_o,
  output logic             valve_o,
  output logic [DUR_W-1:0] dur_o
);
  localparam int WD_W = (WD_LIMIT > 2) ? $clog2(WD_LIMIT) : 1;

  logic             arm_q, arm_n, fire_q, fire_n, trip_q, trip_n, valve_q, valve_n;
  logic [DUR_W-1:0] timer_q, timer_n, dur_q, dur_n;
  logic [WD_W-1:0]  wd_q, wd_n;

  always_comb begin
    arm_n   = arm_q;
    fire_n  = fire_q;
    trip_n  = trip_q;
    timer_n = timer_q;
    dur_n   = dur_q;
    wd_n    = '0;
    // hardware timing of an open valve
    if (valve_q) begin
      wd_n = wd_q + 1'b1;
      if (timer_q == DUR_W'(1)) begin
        fire_n  = 1'b0;
        timer_n = '0;
      end else begin
        timer_n = timer_q - 1'b1;
      end
    end
    // register writes
    if (cmd.dur_wr) dur_n = wdur;
    if (cmd.arm_wr) arm_n = cmd.arm_val;
    if (cmd.fire_wr) begin
      if (!cmd.fire_val) begin
        fire_n = 1'b0;
      end else if (dur_q != '0) begin
        fire_n  = 1'b1;
        timer_n = dur_q;
      end
    end
    if (cmd.trip_clr) trip_n = 1'b0;
    // watchdog overrides everything
    if (valve_q && (wd_q == WD_W'(WD_LIMIT - 1))) begin
      trip_n = 1'b1;
      arm_n  = 1'b0;
      fire_n = 1'b0;
      wd_n   = '0;
    end
    if (cutoff) fire_n = 1'b0;
    valve_n = arm_n && fire_n && !cutoff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      fire_q  <= 1'b0;
      trip_q  <= 1'b0;
      valve_q <= 1'b0;
      timer_q <= '0;
      dur_q   <= '0;
      wd_q    <= '0;
    end else begin
      arm_q   <= arm_n;
      fire_q  <= fire_n;
      trip_q  <= trip_n;
      valve_q <= valve_n;
      timer_q <= timer_n;
      dur_q   <= dur_n;
      wd_q    <= wd_n;
    end
  end

  assign arm_o   = arm_q;
  assign fire_o  = fire_q;
  assign trip_o  = trip_q;
  assign valve_o = valve_q;
  assign dur_o   = dur_q;

  // R2
  valve_gate_chk: assert property (@(posedge clk) disable iff (rst) valve_q |-> (arm_q && fire_q));
  // R8
  cutoff_close_chk: assert property (@(posedge clk) disable iff (rst) cutoff |=> !valve_q);
  // R6
  wd_bound_chk: assert property (@(posedge clk) disable iff (rst) valve_q |-> (int'(wd_q) < WD_LIMIT));
  // R6
  trip_disarm_chk: assert property (@(posedge clk) disable iff (rst) $rose(trip_q) |-> (!arm_q && !valve_q));
  // R3
  done_close_chk: assert property (@(posedge clk) disable iff (rst)
    (valve_q && timer_q == DUR_W'(1) && !cmd.fire_wr) |=> !valve_q);
endmodule

// File: rtl/thr_iso.sv
module thr_iso #(
  parameter int NUM_ISO = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NUM_ISO-1:0] wval,
  input  logic               cutoff,
  output logic [NUM_ISO-1:0] en_o,
  output logic [NUM_ISO-1:0] valve_o
);
  logic [NUM_ISO-1:0] en_q, en_n, valve_q;

  assign en_n = wr ? wval : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      valve_q <= '0;
    end else begin
      en_q    <= en_n;
      valve_q <= cutoff ? '0 : en_n;
    end
  end

  assign en_o    = en_q;
  assign valve_o = valve_q;

  // R8
  iso_cut_chk: assert property (@(posedge clk) disable iff (rst) cutoff |=> (valve_q == '0));
  // R9
  iso_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!cutoff && wr) |=> (valve_q == $past(wval)));
endmodule

// File: rtl/thr_guard_ctrl.sv
module thr_guard_ctrl
  import thr_guard_pkg::*;
#(
  parameter int NUM_THR  = 12,
  parameter int NUM_ISO  = 2,
  parameter int DUR_W    = 16,
  parameter int WD_LIMIT = 50000,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic               iso_cutoff,
  output logic [NUM_THR-1:0] thr_valve,
  output logic [NUM_ISO-1:0] iso_valve
);
  chan_cmd_t [NUM_THR-1:0]  cmd;
  logic [NUM_THR-1:0]       arm_v, fire_v, trip_v, valve_v;
  logic [NUM_ISO-1:0]       iso_en;
  logic [NUM_THR*DUR_W-1:0] dur_flat;
  logic                     iso_wr;

  thr_regif #(
    .NUM_THR(NUM_THR), .NUM_ISO(NUM_ISO), .DUR_W(DUR_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .arm_v(arm_v), .fire_v(fire_v), .trip_v(trip_v), .valve_v(valve_v), .iso_v(iso_en),
    .dur_flat(dur_flat), .cmd(cmd), .iso_wr(iso_wr), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar i = 0; i < NUM_THR; i++) begin : g_chan
    thr_channel #(.DUR_W(DUR_W), .WD_LIMIT(WD_LIMIT)) u_chan (
      .clk(clk), .rst(rst), .cmd(cmd[i]), .wdur(reg_wdata[DUR_W-1:0]), .cutoff(iso_cutoff),
      .arm_o(arm_v[i]), .fire_o(fire_v[i]), .trip_o(trip_v[i]), .valve_o(valve_v[i]),
      .dur_o(dur_flat[i*DUR_W +: DUR_W])
    );
  end

  thr_iso #(.NUM_ISO(NUM_ISO)) u_iso (
    .clk(clk), .rst(rst), .wr(iso_wr), .wval(reg_wdata[NUM_ISO-1:0]), .cutoff(iso_cutoff),
    .en_o(iso_en), .valve_o(iso_valve)
  );

  assign thr_valve = valve_v;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (thr_valve == '0 && iso_valve == '0));
endmodule

// File: tb/thr_guard_ctrl_test.sv
module thr_guard_ctrl_test;
  localparam int NT = 12, NI = 2, AW = 5, DW = 32, WD = 20;
  localparam int A_ARM = 0, A_FIRE = 1, A_ISO = 2, A_TRIP = 3, A_VALVE = 4, A_DUR = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0, iso_cutoff = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid;
  logic [NT-1:0] thr_valve;
  logic [NI-1:0] iso_valve;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [DW-1:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  thr_guard_ctrl #(.NUM_THR(NT), .NUM_ISO(NI), .DUR_W(16), .WD_LIMIT(WD),
                   .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .iso_cutoff(iso_cutoff), .thr_valve(thr_valve), .iso_valve(iso_valve));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic count_open(input int bit_i, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      if (thr_valve[bit_i]) n++;
      @(posedge clk); #1;
    end
  endtask

  // monitor: pop and compare read results
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected read data: actual %0h expected none", reg_rdata);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 thruster valves", DW'(thr_valve), 0);
    chk("R1 iso valves", DW'(iso_valve), 0);
    rd(A_ARM, 0, "R1 arm reg");
    rd(A_FIRE, 0, "R1 fire reg");
    rd(A_ISO, 0, "R1 iso reg");
    rd(A_TRIP, 0, "R1 trip reg");

    // R9 isolation enables
    wr(A_ISO, 3);
    chk("R9 iso open both", DW'(iso_valve), 3);
    rd(A_ISO, 3, "R9 iso reg");
    wr(A_ISO, 1);
    chk("R9 iso open one", DW'(iso_valve), 1);

    // R2 fire without arm
    wr(A_DUR + 1, 4);
    rd(A_DUR + 1, 4, "R3 duration readback");
    wr(A_FIRE, 32'h002);
    chk("R2 unarmed stays closed", DW'(thr_valve), 0);
    rd(A_FIRE, 32'h002, "R2 fire bit held");
    wr(A_FIRE, 0);
    wr(A_ARM, 32'h002);
    chk("R2 armed without fire closed", DW'(thr_valve), 0);

    // R3 timed pulse
    wr(A_DUR + 0, 5);
    wr(A_ARM, 32'h003);
    wr(A_FIRE, 32'h001);
    count_open(0, 8, n);
    chk("R3 pulse length", n, 5);
    rd(A_FIRE, 0, "R3 fire self-clears");
    rd(A_ARM, 32'h003, "R3 arm kept");

    // R4 zero duration ignored
    wr(A_DUR + 5, 0);
    wr(A_ARM, 32'h020);
    wr(A_FIRE, 32'h020);
    chk("R4 zero duration closed", DW'(thr_valve), 0);
    rd(A_FIRE, 0, "R4 fire not set");

    // R5 disarm pause and resume
    wr(A_DUR + 2, 10);
    wr(A_ARM, 32'h004);
    wr(A_FIRE, 32'h004);
    repeat (3) @(posedge clk);
    #1;
    wr(A_ARM, 0);
    chk("R5 disarm closes", DW'(thr_valve), 0);
    rd(A_FIRE, 32'h004, "R5 fire kept");
    repeat (5) @(posedge clk);
    #1;
    chk("R5 stays closed", DW'(thr_valve), 0);
    wr(A_ARM, 32'h004);
    count_open(2, 12, n);
    chk("R5 remaining time", n, 6);

    // R6 watchdog trip
    wr(A_DUR + 7, 100);
    wr(A_ARM, 32'h080);
    wr(A_FIRE, 32'h080);
    count_open(7, 30, n);
    chk("R6 watchdog open cycles", n, WD);
    rd(A_TRIP, 32'h080, "R6 trip set");
    rd(A_ARM, 0, "R6 arm cleared");
    rd(A_FIRE, 0, "R6 fire cleared");

    // R7 write-one-to-clear
    wr(A_TRIP, 0);
    rd(A_TRIP, 32'h080, "R7 zero write keeps trip");
    wr(A_TRIP, 32'h080);
    rd(A_TRIP, 0, "R7 one write clears trip");

    // R10 valve status and R8 cutoff
    wr(A_DUR + 3, 50);
    wr(A_ARM, 32'hFFF);
    wr(A_ISO, 3);
    wr(A_FIRE, 32'h008);
    rd(A_VALVE, 32'h008, "R10 live valve status");
    iso_cutoff = 1'b1;
    @(posedge clk); #1;
    chk("R8 thrusters closed", DW'(thr_valve), 0);
    chk("R8 iso closed", DW'(iso_valve), 0);
    rd(A_FIRE, 0, "R8 fire cleared");
    rd(A_ARM, 32'hFFF, "R8 arm kept");
    rd(A_ISO, 3, "R8 iso enables kept");
    iso_cutoff = 1'b0;
    @(posedge clk); #1;
    chk("R8 iso reopens", DW'(iso_valve), 3);
    chk("R8 thrusters stay closed", DW'(thr_valve), 0);

    // R10 unmapped reads
    rd(31, 0, "R10 unmapped 0x1F");
    rd(10, 0, "R10 unmapped 0x0A");

    repeat (3) @(posedge clk);
    #1;
    chk("R10 all reads returned", sb.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule